// File: doc/BRIEF.md
# Hardwired Execute-Phase Control Generator

This block is the timing and control section of a small accumulator machine with one shared bus. Every register, and the memory port, sits on that bus under a 3-bit datapath address. The block issues a read-source code, which picks the unit that drives the bus, and a write-destination code, which picks the unit that loads from it. It also drives one-hot ALU operation lines, a PC-increment strobe and a halt strobe. Timing comes from a one-hot ring counter. An opcode decoder raises one line per instruction. A combinational control matrix combines the current timing state with the decoded line and gives the pattern for that cycle.

The block starts at T0 with the instruction register already loaded. It sees the opcode, the two skip-condition bits from the instruction and the accumulator's sign and zero flags. Each instruction ends with a counter-reset cycle, which sends the ring back to T0. Instructions therefore take different numbers of cycles. The datapath addresses are: 0 none, 1 MAR, 2 PC, 3 MBR, 4 AC, 5 memory word at MAR, 6 input register (read) or output register (write), 7 instruction address field (read). ALU lines are bit 0 add, bit 1 subtract, bit 2 clear and bit 3 pass-bus. All zero means the ALU does nothing.

Top module: `hw_ctrl_unit`

## Requirements
- R1: While reset is low the timing state is T0 (`t_state_o` = 1). After reset it always holds exactly one set bit.
- R2: Without counter reset the timing state moves one step per clock (bit k to bit k+1). The clock after `cnt_rst_o` is high it is T0. A counter-reset cycle drives no read, write or ALU code.
- R3: Opcode 3 (add) gives T0 7→1, T1 5→3, T2 3→4 with ALU bit 0, T3 counter reset. Opcode 4 (subtract) is the same with ALU bit 1 at T2.
- R4: Opcode 1 (load) gives T0 7→1, T1 5→3, T2 3→4 with ALU bit 3, T3 counter reset. Opcode 2 (store) gives T0 7→1, T1 4→3, T2 3→5, T3 counter reset.
- R5: Opcode 5 (input) gives T0 6→4 with ALU bit 3. Opcode 6 (output) gives T0 4→6. Opcode 10 (clear) gives T0 read 0, write 4, ALU bit 2. Each ends with counter reset at T1.
- R6: Opcode 8 (skip) raises `pc_inc_o` at T0 when its condition holds and ends at T1. Condition bits 00 test AC negative, 01 test AC zero, 10 test AC positive (not negative and not zero), and 11 never skips.
- R7: Opcode 9 (jump) gives T0 7→2 and counter reset at T1. Opcode 12 (indirect jump) gives T0 7→1, T1 5→3, T2 3→2, T3 counter reset.
- R8: Opcode 11 (indirect add) gives T0 7→1, T1 5→3, T2 3→1, T3 5→3, T4 3→4 with ALU bit 0, T5 counter reset.
- R9: Opcode 0 (jump-and-store) gives T0 2→3, T1 7→1, T2 3→5, T3 7→2, T4 `pc_inc_o` only, T5 counter reset.
- R10: Opcode 7 (halt) raises `halt_o` and `cnt_rst_o` together at T0 and nothing else.
- R11: Opcodes 13, 14 and 15 raise only `cnt_rst_o` at T0.
- R12: At most one ALU line is high. Exactly one is high in every cycle that writes address 4.
- R13: The number of cycles from T0 to the counter-reset cycle is 0 for halt and unused opcodes, 1 for input, output, clear, skip and jump, 3 for load, store, add, subtract and indirect jump, and 5 for indirect add and jump-and-store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | OP_W (4) | Opcode field of the current instruction, held for the whole instruction |
| skip_cond_i | input | 2 | Skip-condition field of the instruction |
| ac_neg_i | input | 1 | Accumulator sign flag |
| ac_zero_i | input | 1 | Accumulator zero flag |
| t_state_o | output | T_STEPS (8) | One-hot timing state, bit k = Tk |
| rd_sel_o | output | 3 | Bus source datapath address |
| wr_sel_o | output | 3 | Bus destination datapath address |
| alu_ctl_o | output | 4 | ALU operation lines |
| cnt_rst_o | output | 1 | Counter reset, ends the instruction |
| pc_inc_o | output | 1 | Increment PC |
| halt_o | output | 1 | Stop execution |

## Verification
The hardest case to reach from the ports is an asynchronous reset that arrives partway through a long instruction, with the ring sitting at T2 of an indirect add. The stimulus forces it by holding that opcode for two clocks and then dropping reset between edges. The skip conditions also need care, because the result depends on the condition bits and the flag pair together. A directed sweep covers every condition against negative, zero and positive accumulators. Seeded random instruction streams then mix all sixteen opcodes, including the unused ones, so that different instruction lengths follow one another.

// File: rtl/hw_ctrl_pkg.sv
package hw_ctrl_pkg;

  localparam int SEL_W = 3;
  localparam int ALU_W = 4;

  // datapath addresses on the shared bus
  localparam logic [SEL_W-1:0] DP_NONE = 3'd0;
  localparam logic [SEL_W-1:0] DP_MAR  = 3'd1;
  localparam logic [SEL_W-1:0] DP_PC   = 3'd2;
  localparam logic [SEL_W-1:0] DP_MBR  = 3'd3;
  localparam logic [SEL_W-1:0] DP_AC   = 3'd4;
  localparam logic [SEL_W-1:0] DP_MEM  = 3'd5;
  localparam logic [SEL_W-1:0] DP_IO   = 3'd6;
  localparam logic [SEL_W-1:0] DP_IR   = 3'd7;

  // alu lines
  localparam logic [ALU_W-1:0] ALU_NOP  = 4'b0000;
  localparam logic [ALU_W-1:0] ALU_ADD  = 4'b0001;
  localparam logic [ALU_W-1:0] ALU_SUB  = 4'b0010;
  localparam logic [ALU_W-1:0] ALU_CLR  = 4'b0100;
  localparam logic [ALU_W-1:0] ALU_PASS = 4'b1000;

  // opcode line indices
  localparam int OP_JNS   = 0;
  localparam int OP_LOAD  = 1;
  localparam int OP_STORE = 2;
  localparam int OP_ADD   = 3;
  localparam int OP_SUBT  = 4;
  localparam int OP_IN    = 5;
  localparam int OP_OUT   = 6;
  localparam int OP_HALT  = 7;
  localparam int OP_SKIP  = 8;
  localparam int OP_JUMP  = 9;
  localparam int OP_CLEAR = 10;
  localparam int OP_ADDI  = 11;
  localparam int OP_JUMPI = 12;

  typedef struct packed {
    logic [SEL_W-1:0] rd;
    logic [SEL_W-1:0] wr;
    logic [ALU_W-1:0] alu;
    logic             cr;
    logic             pc_inc;
    logic             halt;
  } ctrl_t;

  function automatic ctrl_t xfer(logic [SEL_W-1:0] r, logic [SEL_W-1:0] w,
                                 logic [ALU_W-1:0] a);
    ctrl_t c;
    c        = '0;
    c.rd     = r;
    c.wr     = w;
    c.alu    = a;
    return c;
  endfunction

  function automatic ctrl_t end_step();
    ctrl_t c;
    c    = '0;
    c.cr = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/hw_ring_counter.sv
module hw_ring_counter #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [N-1:0] t_o
);

  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[i] <= 1'b1;
        else         q[i] <= clr_i | q[N-1];
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[i] <= 1'b0;
        else         q[i] <= ~clr_i & q[i-1];
      end
    end
  end

  assign t_o = q;

endmodule

// File: rtl/hw_op_decoder.sv
module hw_op_decoder #(
  parameter int OP_W = 4,
  localparam int NOPS = 1 << OP_W
) (
  input  logic [OP_W-1:0] opcode_i,
  output logic [NOPS-1:0] line_o
);

  for (genvar k = 0; k < NOPS; k++) begin : g_line
    assign line_o[k] = (opcode_i == OP_W'(k));
  end

endmodule

// File: rtl/hw_skip_eval.sv
module hw_skip_eval (
  input  logic [1:0] cond_i,
  input  logic       neg_i,
  input  logic       zero_i,
  output logic       take_o
);

  always_comb begin
    unique case (cond_i)
      2'b00:   take_o = neg_i;
      2'b01:   take_o = zero_i;
      2'b10:   take_o = ~neg_i & ~zero_i;
      default: take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/hw_ctrl_matrix.sv
module hw_ctrl_matrix
  import hw_ctrl_pkg::*;
#(
  parameter int NOPS = 16,
  parameter int T_N  = 8,
  localparam int STEP_W = $clog2(T_N)
) (
  input  logic [NOPS-1:0] op_line_i,
  input  logic [T_N-1:0]  t_state_i,
  input  logic            skip_take_i,
  output ctrl_t           ctrl_o
);

  logic [STEP_W-1:0] step;
  ctrl_t             c;

  always_comb begin
    step = '0;
    for (int i = 0; i < T_N; i++) begin
      if (t_state_i[i]) step = STEP_W'(i);
    end
  end

  always_comb begin
    c = '0;
    if (op_line_i[OP_JNS]) begin
      case (int'(step))
        0:       c = xfer(DP_PC,  DP_MBR, ALU_NOP);
        1:       c = xfer(DP_IR,  DP_MAR, ALU_NOP);
        2:       c = xfer(DP_MBR, DP_MEM, ALU_NOP);
        3:       c = xfer(DP_IR,  DP_PC,  ALU_NOP);
        4:       c.pc_inc = 1'b1;
        default: c = end_step();
      endcase
    end else if (op_line_i[OP_LOAD] | op_line_i[OP_ADD] | op_line_i[OP_SUBT]) begin
      case (int'(step))
        0:       c = xfer(DP_IR,  DP_MAR, ALU_NOP);
        1:       c = xfer(DP_MEM, DP_MBR, ALU_NOP);
        2:       c = xfer(DP_MBR, DP_AC,
                          op_line_i[OP_ADD]  ? ALU_ADD :
                          op_line_i[OP_SUBT] ? ALU_SUB : ALU_PASS);
        default: c = end_step();
      endcase
    end else if (op_line_i[OP_STORE]) begin
      case (int'(step))
        0:       c = xfer(DP_IR,  DP_MAR, ALU_NOP);
        1:       c = xfer(DP_AC,  DP_MBR, ALU_NOP);
        2:       c = xfer(DP_MBR, DP_MEM, ALU_NOP);
        default: c = end_step();
      endcase
    end else if (op_line_i[OP_IN]) begin
      if (step == '0) c = xfer(DP_IO, DP_AC, ALU_PASS);
      else            c = end_step();
    end else if (op_line_i[OP_OUT]) begin
      if (step == '0) c = xfer(DP_AC, DP_IO, ALU_NOP);
      else            c = end_step();
    end else if (op_line_i[OP_CLEAR]) begin
      if (step == '0) c = xfer(DP_NONE, DP_AC, ALU_CLR);
      else            c = end_step();
    end else if (op_line_i[OP_JUMP]) begin
      if (step == '0) c = xfer(DP_IR, DP_PC, ALU_NOP);
      else            c = end_step();
    end else if (op_line_i[OP_SKIP]) begin
      if (step == '0) c.pc_inc = skip_take_i;
      else            c = end_step();
    end else if (op_line_i[OP_HALT]) begin
      c      = end_step();
      c.halt = 1'b1;
    end else if (op_line_i[OP_ADDI]) begin
      case (int'(step))
        0:       c = xfer(DP_IR,  DP_MAR, ALU_NOP);
        1:       c = xfer(DP_MEM, DP_MBR, ALU_NOP);
        2:       c = xfer(DP_MBR, DP_MAR, ALU_NOP);
        3:       c = xfer(DP_MEM, DP_MBR, ALU_NOP);
        4:       c = xfer(DP_MBR, DP_AC,  ALU_ADD);
        default: c = end_step();
      endcase
    end else if (op_line_i[OP_JUMPI]) begin
      case (int'(step))
        0:       c = xfer(DP_IR,  DP_MAR, ALU_NOP);
        1:       c = xfer(DP_MEM, DP_MBR, ALU_NOP);
        2:       c = xfer(DP_MBR, DP_PC,  ALU_NOP);
        default: c = end_step();
      endcase
    end else begin
      // unused opcode: retire at once
      c = end_step();
    end
  end

  assign ctrl_o = c;

endmodule

// File: rtl/hw_ctrl_unit.sv
module hw_ctrl_unit
  import hw_ctrl_pkg::*;
#(
  parameter int OP_W    = 4,
  parameter int T_STEPS = 8,
  localparam int NOPS   = 1 << OP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OP_W-1:0]    opcode_i,
  input  logic [1:0]         skip_cond_i,
  input  logic               ac_neg_i,
  input  logic               ac_zero_i,
  output logic [T_STEPS-1:0] t_state_o,
  output logic [SEL_W-1:0]   rd_sel_o,
  output logic [SEL_W-1:0]   wr_sel_o,
  output logic [ALU_W-1:0]   alu_ctl_o,
  output logic               cnt_rst_o,
  output logic               pc_inc_o,
  output logic               halt_o
);

  logic [T_STEPS-1:0] t_state;
  logic [NOPS-1:0]    op_line;
  logic               skip_take;
  ctrl_t              ctrl;

  hw_ring_counter #(.N(T_STEPS)) ring_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl.cr),
    .t_o    (t_state)
  );

  hw_op_decoder #(.OP_W(OP_W)) dec_i (
    .opcode_i (opcode_i),
    .line_o   (op_line)
  );

  hw_skip_eval skip_i (
    .cond_i (skip_cond_i),
    .neg_i  (ac_neg_i),
    .zero_i (ac_zero_i),
    .take_o (skip_take)
  );

  hw_ctrl_matrix #(.NOPS(NOPS), .T_N(T_STEPS)) mtx_i (
    .op_line_i   (op_line),
    .t_state_i   (t_state),
    .skip_take_i (skip_take),
    .ctrl_o      (ctrl)
  );

  assign t_state_o = t_state;
  assign rd_sel_o  = ctrl.rd;
  assign wr_sel_o  = ctrl.wr;
  assign alu_ctl_o = ctrl.alu;
  assign cnt_rst_o = ctrl.cr;
  assign pc_inc_o  = ctrl.pc_inc;
  assign halt_o    = ctrl.halt;

endmodule

// File: rtl/hw_ctrl_unit_chk.sv
module hw_ctrl_unit_chk #(
  parameter int OP_W    = 4,
  parameter int T_STEPS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [OP_W-1:0]    opcode_i,
  input logic [1:0]         skip_cond_i,
  input logic               ac_neg_i,
  input logic               ac_zero_i,
  input logic [T_STEPS-1:0] t_state_o,
  input logic [2:0]         rd_sel_o,
  input logic [2:0]         wr_sel_o,
  input logic [3:0]         alu_ctl_o,
  input logic               cnt_rst_o,
  input logic               pc_inc_o,
  input logic               halt_o
);

  // R1
  ring_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(t_state_o));

  // R2
  ring_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |=> (t_state_o == T_STEPS'(1)));

  // R2
  ring_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_rst_o && !t_state_o[T_STEPS-1]) |=> (t_state_o == ($past(t_state_o) << 1)));

  // R2
  cr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |-> (rd_sel_o == 3'd0 && wr_sel_o == 3'd0 && alu_ctl_o == 4'd0));

  // R12
  alu_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alu_ctl_o));

  // R12
  ac_write_alu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_o == 3'd4) |-> ($countones(alu_ctl_o) == 1));

  // R10
  halt_t0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (t_state_o[0] && cnt_rst_o && opcode_i == OP_W'(7)));

  // R6
  pc_inc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |-> (opcode_i == OP_W'(8) || opcode_i == OP_W'(0)));

  // R11
  unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i >= OP_W'(13)) |-> (cnt_rst_o && t_state_o[0]));

endmodule

bind hw_ctrl_unit hw_ctrl_unit_chk #(.OP_W(OP_W), .T_STEPS(T_STEPS)) chk_i (.*);

// File: tb/hw_ctrl_unit_tb_top.sv
module hw_ctrl_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] opcode;
  logic [1:0] cond;
  logic       neg, zero;
  logic [7:0] t_state;
  logic [2:0] rd_sel, wr_sel;
  logic [3:0] alu;
  logic       cr, pc_inc, halt;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  hw_ctrl_unit dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .opcode_i    (opcode),
    .skip_cond_i (cond),
    .ac_neg_i    (neg),
    .ac_zero_i   (zero),
    .t_state_o   (t_state),
    .rd_sel_o    (rd_sel),
    .wr_sel_o    (wr_sel),
    .alu_ctl_o   (alu),
    .cnt_rst_o   (cr),
    .pc_inc_o    (pc_inc),
    .halt_o      (halt)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0:              return "R9";
      4'd1, 4'd2:        return "R4";
      4'd3, 4'd4:        return "R3";
      4'd5, 4'd6, 4'd10: return "R5";
      4'd7:              return "R10";
      4'd8:              return "R6";
      4'd9, 4'd12:       return "R7";
      4'd11:             return "R8";
      default:           return "R11";
    endcase
  endfunction

  // cycles until counter reset, per R13
  function automatic int len_of(logic [3:0] op);
    case (op)
      4'd7, 4'd13, 4'd14, 4'd15:       return 0;
      4'd5, 4'd6, 4'd8, 4'd9, 4'd10:   return 1;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd12:   return 3;
      default:                         return 5;
    endcase
  endfunction

  function automatic logic skip_ok(logic [1:0] c, logic n, logic z);
    case (c)
      2'b00:   return n;
      2'b01:   return z;
      2'b10:   return !n && !z;
      default: return 1'b0;
    endcase
  endfunction

  // packed {rd, wr, alu, cr, pc_inc, halt}
  function automatic logic [12:0] pk(logic [2:0] r, logic [2:0] w, logic [3:0] a,
                                     logic c, logic i, logic h);
    return {r, w, a, c, i, h};
  endfunction

  function automatic logic [12:0] expect_at(logic [3:0] op, logic [1:0] c,
                                            logic n, logic z, int s);
    logic [12:0] e;
    e = 13'd0;
    if (s == len_of(op)) return pk(0, 0, 0, 1, 0, op == 4'd7);
    case (op)
      4'd0: case (s)
        0: e = pk(2, 3, 0, 0, 0, 0);
        1: e = pk(7, 1, 0, 0, 0, 0);
        2: e = pk(3, 5, 0, 0, 0, 0);
        3: e = pk(7, 2, 0, 0, 0, 0);
        default: e = pk(0, 0, 0, 0, 1, 0);
      endcase
      4'd1, 4'd3, 4'd4: case (s)
        0: e = pk(7, 1, 0, 0, 0, 0);
        1: e = pk(5, 3, 0, 0, 0, 0);
        default: e = pk(3, 4, op == 4'd1 ? 4'b1000 : op == 4'd3 ? 4'b0001 : 4'b0010, 0, 0, 0);
      endcase
      4'd2: case (s)
        0: e = pk(7, 1, 0, 0, 0, 0);
        1: e = pk(4, 3, 0, 0, 0, 0);
        default: e = pk(3, 5, 0, 0, 0, 0);
      endcase
      4'd5:  e = pk(6, 4, 4'b1000, 0, 0, 0);
      4'd6:  e = pk(4, 6, 0, 0, 0, 0);
      4'd8:  e = pk(0, 0, 0, 0, skip_ok(c, n, z), 0);
      4'd9:  e = pk(7, 2, 0, 0, 0, 0);
      4'd10: e = pk(0, 4, 4'b0100, 0, 0, 0);
      4'd11: case (s)
        0, 2: e = pk(s == 0 ? 3'd7 : 3'd3, 1, 0, 0, 0, 0);
        1, 3: e = pk(5, 3, 0, 0, 0, 0);
        default: e = pk(3, 4, 4'b0001, 0, 0, 0);
      endcase
      4'd12: case (s)
        0: e = pk(7, 1, 0, 0, 0, 0);
        1: e = pk(5, 3, 0, 0, 0, 0);
        default: e = pk(3, 2, 0, 0, 0, 0);
      endcase
      default: e = 13'd0;
    endcase
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called just after a posedge with the ring at T0
  task automatic run_instr(logic [3:0] op, logic [1:0] c, logic n, logic z);
    logic [12:0] got, exp;
    bool_done: begin end
    opcode = op; cond = c; neg = n; zero = z;
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      check(t_state == 8'(1 << s), "R2", "timing state", 32'(t_state), 32'(1 << s));
      got = {rd_sel, wr_sel, alu, cr, pc_inc, halt};
      exp = expect_at(op, c, n, z, s);
      check(got == exp, req_of(op), $sformatf("op %0d step T%0d", op, s), 32'(got), 32'(exp));
      if (wr_sel == 3'd4)
        check($countones(alu) == 1, "R12", "alu lines on AC write", 32'(alu), 32'd1);
      if (cr) begin
        check(s == len_of(op), "R13", $sformatf("length op %0d", op), 32'(s), 32'(len_of(op)));
        @(posedge clk); #1;
        return;
      end
    end
    check(1'b0, "R13", "no counter reset within 8 steps", 32'd8, 32'(len_of(op)));
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0; opcode = 4'd7; cond = 2'd0; neg = 1'b0; zero = 1'b0;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    check(t_state == 8'h01, "R1", "state in reset", 32'(t_state), 32'h01);
    @(posedge clk); #1 rst_n = 1'b1;

    // every opcode once
    for (int op = 0; op < 16; op++) run_instr(4'(op), 2'd0, 1'b0, 1'b0);

    // skip conditions against negative, zero and positive AC (R6)
    for (int cc = 0; cc < 4; cc++) begin
      run_instr(4'd8, 2'(cc), 1'b1, 1'b0);
      run_instr(4'd8, 2'(cc), 1'b0, 1'b1);
      run_instr(4'd8, 2'(cc), 1'b0, 1'b0);
    end

    // long instructions back to back
    run_instr(4'd11, 2'd0, 1'b0, 1'b0);
    run_instr(4'd0,  2'd0, 1'b0, 1'b0);
    run_instr(4'd7,  2'd0, 1'b0, 1'b0);
    run_instr(4'd15, 2'd0, 1'b0, 1'b0);

    // reset in the middle of an indirect add (R1)
    opcode = 4'd11;
    @(posedge clk); @(posedge clk); #1;
    check(t_state == 8'h04, "R2", "state before mid reset", 32'(t_state), 32'h04);
    rst_n = 1'b0; #1;
    check(t_state == 8'h01, "R1", "async reset to T0", 32'(t_state), 32'h01);
    @(posedge clk); #1 rst_n = 1'b1;
    run_instr(4'd3, 2'd0, 1'b0, 1'b0);

    // seeded random stream
    for (int k = 0; k < 400; k++) begin
      int f;
      f = int'($urandom % 3);
      run_instr(4'($urandom % 16), 2'($urandom % 4), f == 0, f == 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule